// File: doc/BRIEF.md
# Programmable Frame Sync Pulse Locator

This block places frame-sync and multiframe-sync pulses at a bit position within a system-bus frame that software selects. The position is given as a time slot and a bit inside that slot. A free-running bit counter and a frame counter track where the bus currently is. The bit counter runs on the bus clock, one count per bit. The frame counter marks where each multiframe starts.

The block works in one of two directions. In generate mode it drives the two sync outputs once per frame and once per multiframe. In accept mode it takes sync pulses from outside and compares each one with the programmed position. A pulse that arrives on the wrong bit, or a multiframe pulse that arrives in the wrong frame, sets a sticky error flag. The counters are then reloaded, so the block follows the external timing from that point on. The same position serves the frame pulse and the multiframe pulse in both directions.

Top module: `fsync_locator`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the bit counter and the frame counter are zero and `align_err` is 0. In that first cycle the bus is on bit 0 of frame 0.
- R2: The sync position is `slot_ofs`*8 + `bit_ofs`, counted in bits from the frame start. `bit_ofs`=0 selects the first bit of the slot, and with `slot_ofs`=0 that is the frame's framing bit. `bit_ofs`=7 selects the eighth bit of the slot.
- R3: When the sync position is FRAME_BITS or more, it wraps modulo FRAME_BITS.
- R4: With `acc_mode`=0 (generate), `fsync_out` is high for exactly one cycle per frame, in the cycle where the bit counter equals the sync position.
- R5: `msync_out` is high only in a cycle where `fsync_out` is high and the frame counter is zero. It therefore fires once every MF_FRAMES frames.
- R6: With `acc_mode`=1 (accept), `fsync_out` and `msync_out` stay low.
- R7: In accept mode, a pulse on `fsync_in` at the sync position does not set `align_err`. Neither does a pulse on `msync_in` at the sync position in frame 0.
- R8: In accept mode, a pulse on `fsync_in` or `msync_in` at any other bit sets `align_err` in the next cycle. It also reloads the bit counter so that the pulse cycle counts as the sync position.
- R9: In accept mode, a pulse on `msync_in` makes the pulse's frame frame 0. If the frame counter was not zero, `align_err` is set in the next cycle.
- R10: `align_err` stays set until reset, whatever the mode or inputs.
- R11: The bit counter counts 0 to FRAME_BITS-1 and wraps. The frame counter advances on each wrap and counts 0 to MF_FRAMES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_mode | input | 1 | 0 = generate sync pulses, 1 = accept external sync pulses |
| slot_ofs | input | 7 | Time-slot part of the sync position |
| bit_ofs | input | 3 | Bit-in-slot part of the sync position (0 = first bit) |
| fsync_in | input | 1 | External frame-sync pulse (accept mode) |
| msync_in | input | 1 | External multiframe-sync pulse (accept mode) |
| fsync_out | output | 1 | Generated frame-sync pulse |
| msync_out | output | 1 | Generated multiframe-sync pulse |
| align_err | output | 1 | Sticky flag for a misaligned accepted pulse |

## Verification
The bench programs several positions: the framing bit, the eighth bit of a slot, the last bit of the frame, and a value past the frame end. A design that drops the ×8 weighting, swaps the bit numbering, or skips the modulo wrap puts the pulse in the wrong cycle. A design that compares against the raw 10-bit sum never fires at all. The bench also aligns an external pulse on purpose and then checks the realigned timing in generate mode. A block that flags the error but does not reload keeps pulsing at the old position. A block that reloads to the pulse cycle itself, instead of the cycle after, is off by one bit. A multiframe pulse is sent in frame 2. A design that ignores it puts `msync_out` in the old frame, and one that fails to flag it leaves `align_err` low.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    localparam int SLOT_W = 7;
    localparam int BIT_W  = 3;
    localparam int OFS_W  = SLOT_W + BIT_W;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_ACC = 1'b1
    } sync_mode_e;
endpackage

// File: rtl/fsl_offset.sv
module fsl_offset
    import fsl_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    localparam int BW = $clog2(FRAME_BITS)
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [BIT_W-1:0]  bit_i,
    output logic [BW-1:0]     tgt_o
);
    logic [OFS_W-1:0] comb_ofs;
    logic [31:0]      wrapped;

    always_comb begin
        // slot weight is 8 bits; bit part fills the low three positions
        comb_ofs = {slot_i, bit_i};
        wrapped  = 32'(comb_ofs) % 32'(FRAME_BITS);
        tgt_o    = BW'(wrapped);
    end

    always_comb begin
        a_r3_target_in_frame: assert (32'(tgt_o) < 32'(FRAME_BITS))
            else $error("sync target outside frame");
    end
endmodule

// File: rtl/fsl_align.sv
module fsl_align
    import fsl_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int BW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  sync_mode_e    mode_i,
    input  logic          fs_in_i,
    input  logic          ms_in_i,
    input  logic [BW-1:0] bit_q_i,
    input  logic [FW-1:0] frm_q_i,
    input  logic [BW-1:0] tgt_i,
    output logic          realign_o,
    output logic          frm_zero_o,
    output logic          mis_o
);
    logic bit_off;
    logic frm_off;

    always_comb begin
        realign_o  = (mode_i == MODE_ACC) && (fs_in_i || ms_in_i);
        frm_zero_o = (mode_i == MODE_ACC) && ms_in_i;
        bit_off    = bit_q_i != tgt_i;
        frm_off    = ms_in_i && (frm_q_i != '0);
        mis_o      = realign_o && (bit_off || frm_off);
    end
endmodule

// File: rtl/fsl_counter.sv
module fsl_counter #(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int BW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          realign_i,
    input  logic          frm_zero_i,
    input  logic [BW-1:0] tgt_i,
    output logic [BW-1:0] bit_q_o,
    output logic [FW-1:0] frm_q_o
);
    localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);
    localparam logic [FW-1:0] FRM_LAST = FW'(MF_FRAMES - 1);

    typedef struct packed {
        logic [BW-1:0] bitpos;
        logic [FW-1:0] frm;
    } cnt_t;

    cnt_t          st_d, st_q;
    logic [BW-1:0] base_bit;
    logic [FW-1:0] base_frm;

    always_comb begin
        base_bit = realign_i  ? tgt_i : st_q.bitpos;
        base_frm = frm_zero_i ? '0    : st_q.frm;
        st_d     = st_q;
        if (base_bit == BIT_LAST) begin
            st_d.bitpos = '0;
            st_d.frm    = (base_frm == FRM_LAST) ? '0 : base_frm + 1'b1;
        end else begin
            st_d.bitpos = base_bit + 1'b1;
            st_d.frm    = base_frm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_q_o = st_q.bitpos;
    assign frm_q_o = st_q.frm;

    a_r11_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.bitpos) < 32'(FRAME_BITS));
    a_r11_frm_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.frm) < 32'(MF_FRAMES));
    a_r11_bit_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign_i && st_q.bitpos != BIT_LAST) |=> st_q.bitpos == $past(st_q.bitpos) + 1'b1);
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (realign_i && tgt_i != BIT_LAST) |=> st_q.bitpos == $past(tgt_i) + 1'b1);
endmodule

// File: rtl/fsync_locator.sv
module fsync_locator
    import fsl_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MF_FRAMES  = 16,
    localparam int BW = $clog2(FRAME_BITS),
    localparam int FW = $clog2(MF_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_mode,
    input  logic [SLOT_W-1:0] slot_ofs,
    input  logic [BIT_W-1:0]  bit_ofs,
    input  logic              fsync_in,
    input  logic              msync_in,
    output logic              fsync_out,
    output logic              msync_out,
    output logic              align_err
);
    typedef struct packed {
        logic err;
    } top_t;

    sync_mode_e    mode;
    logic [BW-1:0] tgt;
    logic [BW-1:0] bit_q;
    logic [FW-1:0] frm_q;
    logic          realign;
    logic          frm_zero;
    logic          mis;
    top_t          st_d, st_q;

    assign mode = acc_mode ? MODE_ACC : MODE_GEN;

    fsl_offset #(.FRAME_BITS(FRAME_BITS)) u_ofs (
        .slot_i (slot_ofs),
        .bit_i  (bit_ofs),
        .tgt_o  (tgt)
    );

    fsl_align #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) u_align (
        .mode_i     (mode),
        .fs_in_i    (fsync_in),
        .ms_in_i    (msync_in),
        .bit_q_i    (bit_q),
        .frm_q_i    (frm_q),
        .tgt_i      (tgt),
        .realign_o  (realign),
        .frm_zero_o (frm_zero),
        .mis_o      (mis)
    );

    fsl_counter #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .realign_i  (realign),
        .frm_zero_i (frm_zero),
        .tgt_i      (tgt),
        .bit_q_o    (bit_q),
        .frm_q_o    (frm_q)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = st_q.err || mis;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fsync_out = (mode == MODE_GEN) && (bit_q == tgt);
    assign msync_out = fsync_out && (frm_q == '0);
    assign align_err = st_q.err;

    a_r5_msync_with_fsync: assert property (@(posedge clk) disable iff (!rst_n)
        msync_out |-> fsync_out);
    a_r6_quiet_in_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mode |-> (!fsync_out && !msync_out));
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);
    a_r8_misaligned_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode && fsync_in && bit_q != tgt) |=> align_err);
    a_r9_frame_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode && msync_in && frm_q != '0) |=> align_err);
endmodule

// File: tb/fsync_locator_tb.sv
`timescale 1ns/1ps
module fsync_locator_tb;
    localparam int FB = 40;
    localparam int MF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_mode = 1'b0;
    logic [6:0] slot_ofs = '0;
    logic [2:0] bit_ofs = '0;
    logic       fsync_in = 1'b0;
    logic       msync_in = 1'b0;
    logic       fsync_out, msync_out, align_err;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    fsync_locator #(.FRAME_BITS(FB), .MF_FRAMES(MF)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_mode(acc_mode),
        .slot_ofs(slot_ofs), .bit_ofs(bit_ofs),
        .fsync_in(fsync_in), .msync_in(msync_in),
        .fsync_out(fsync_out), .msync_out(msync_out), .align_err(align_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at k=%0d: actual %0d expected %0d", req, k, act, exp);
        end
    endtask

    task automatic do_reset(input logic acc, input int ts, input int b);
        @(negedge clk);
        rst_n    = 1'b0;
        acc_mode = acc;
        slot_ofs = 7'(ts);
        bit_ofs  = 3'(b);
        fsync_in = 1'b0;
        msync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_k(input int target);
        while (k != target) @(negedge clk);
    endtask

    // R1: state right after reset
    task automatic t_reset_state();
        do_reset(1'b0, 0, 0);
        check(align_err == 1'b0, "R1 err", int'(align_err), 0);
        check(fsync_out == 1'b1, "R1 bit0 fsync", int'(fsync_out), 1);
        check(msync_out == 1'b1, "R1 frame0 msync", int'(msync_out), 1);
    endtask

    // R2 R3 R4 R5 R11: generate mode timing over more than one multiframe
    task automatic t_gen(input int ts, input int b, input int tgt, input string req);
        do_reset(1'b0, ts, b);
        for (int n = 0; n < MF * FB + FB; n++) begin
            bit exp_fs = (k % FB) == tgt;
            bit exp_ms = exp_fs && ((k / FB) % MF) == 0;
            check(fsync_out == exp_fs, {req, " R4 fsync"}, int'(fsync_out), int'(exp_fs));
            check(msync_out == exp_ms, {req, " R5 msync"}, int'(msync_out), int'(exp_ms));
            @(negedge clk);
        end
    endtask

    // R6 R7: aligned external pulses raise no error and outputs stay low
    task automatic t_accept_ok();
        do_reset(1'b1, 1, 2);
        wait_k(10);
        fsync_in = 1'b1; msync_in = 1'b1;
        check(fsync_out == 1'b0 && msync_out == 1'b0, "R6 outputs low",
              int'(fsync_out | msync_out), 0);
        @(negedge clk);
        fsync_in = 1'b0; msync_in = 1'b0;
        check(align_err == 1'b0, "R7 aligned msync", int'(align_err), 0);
        wait_k(FB + 10);
        fsync_in = 1'b1;
        @(negedge clk);
        fsync_in = 1'b0;
        check(align_err == 1'b0, "R7 aligned fsync", int'(align_err), 0);
        check(fsync_out == 1'b0, "R6 fsync low", int'(fsync_out), 0);
    endtask

    // R8 R10: misaligned pulse flags and realigns
    task automatic t_misalign();
        do_reset(1'b1, 1, 2);
        wait_k(14);
        check(align_err == 1'b0, "R8 no err before", int'(align_err), 0);
        @(negedge clk);
        fsync_in = 1'b1;
        @(negedge clk);
        fsync_in = 1'b0;
        acc_mode = 1'b0;
        check(align_err == 1'b1, "R8 err set", int'(align_err), 1);
        for (int n = 0; n < 2 * FB; n++) begin
            bit exp_fs = ((k - 15) % FB) == 0;
            check(fsync_out == exp_fs, "R8 realigned fsync", int'(fsync_out), int'(exp_fs));
            @(negedge clk);
        end
        check(align_err == 1'b1, "R10 err sticky", int'(align_err), 1);
    endtask

    // R9: multiframe pulse in frame 2 realigns frame counter
    task automatic t_mframe();
        int p;
        do_reset(1'b1, 1, 2);
        p = 2 * FB + 10;
        wait_k(p);
        fsync_in = 1'b1; msync_in = 1'b1;
        @(negedge clk);
        fsync_in = 1'b0; msync_in = 1'b0;
        acc_mode = 1'b0;
        check(align_err == 1'b1, "R9 frame err", int'(align_err), 1);
        for (int n = 0; n < MF * FB + FB; n++) begin
            bit exp_fs = ((k - p) % FB) == 0;
            bit exp_ms = exp_fs && (((k - p) / FB) % MF) == 0;
            check(msync_out == exp_ms, "R9 realigned msync", int'(msync_out), int'(exp_ms));
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_gen(0, 0, 0,  "R2 framing bit");
        t_gen(2, 7, 23, "R2 eighth bit");
        t_gen(4, 7, 39, "R11 last bit");
        t_gen(6, 3, 11, "R3 wrap");
        t_accept_ok();
        t_misalign();
        t_mframe();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule